// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block RAM

This block is an 18 Kb synchronous memory with two independent access ports, A and B. Each port has its own enable, write enable, address, write data and read data. A parameter gives each port a shape: 16384×1, 8192×2, 4096×4, 2048×9, 1024×18 or 512×36. The two shapes need not match, so a word written through a wide port can be read back in pieces through a narrow one, and the other way round. The 9-, 18- and 36-bit shapes carry one extra bit for every eight data bits. These extra bits are held and returned exactly like data, with no parity generated or checked. A port that uses only eight, sixteen or thirty-two bits takes the 9-, 18- or 36-bit shape and leaves its top bits unused.

Internally the memory is 512 rows of 36 bits: 32 data bits in row bits 31:0 and 4 extra bits in row bits 35:32. A narrow port reaches one slot of a row. Per port, a parameter selects what the read output shows during a write: the previous contents, the data being written, or its own earlier value. A second parameter adds an output pipeline register. Both ports sample on one shared clock edge. A synchronous active-high reset clears the read outputs and leaves the stored contents as they are.

Top module: `mwdp_ram`

## Requirements
- R1: Port width parameter W is one of 1, 2, 4, 9, 18, 36. The port address is 9 + log2(32/D) bits, where D is the data bits per port word (D = W for W below 9, D = 8·W/9 otherwise). This gives 14, 13, 12, 11, 10 and 9 address bits.
- R2: A port address selects row = addr >> log2(32/D) and slot s = the low log2(32/D) address bits. The port's data bits map to row bits [s·D +: D]. Its P = W/9 extra bits (none for W below 9) map to row bits [32 + s·P +: P]. On the port, the extra bits sit above the data bits, as {extra, data}. Slot 0 is the least significant.
- R3: Without the output register, a read whose address is captured at a clock edge shows its data on the read output right after that edge.
- R4: With the output register, the same data appears one edge later. Right after the capturing edge the output still shows its previous value.
- R5: In read-first mode, a write shows the slot's contents from before the write.
- R6: In write-first mode, a write shows the data being written.
- R7: In no-change mode, a write leaves the read output unchanged.
- R8: With enable low, a port ignores its address, data and write enable. It writes nothing, and its read output holds.
- R9: The read output keeps the last read value over idle cycles, until the next enabled access.
- R10: Reset clears both read outputs to zero. Stored contents are not cleared.
- R11: Both ports may write in the same cycle to bits that do not overlap, and both writes are stored. Writes to overlapping bits in one cycle leave those bits undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the read outputs |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | A_AW | Port A address |
| a_din | input | A_WIDTH | Port A write data, {extra, data} |
| a_dout | output | A_WIDTH | Port A read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | B_AW | Port B address |
| b_din | input | B_WIDTH | Port B write data, {extra, data} |
| b_dout | output | B_WIDTH | Port B read data |

## Verification
A port without the output register must show its read or write result after the edge that captures the access. A port with the register must show it one edge later and still show its earlier value in between. The bench drives every access at a falling edge and reads the outputs at the falling edge that follows the edge where each result is due. For registered ports it also reads the value in between to confirm the extra cycle of latency. The hold and ignore checks read the output after several idle edges, then read the affected rows back through the normal ports.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;

    localparam int ROWS     = 512;
    localparam int ROW_AW   = $clog2(ROWS);
    localparam int DATA_W   = 32;
    localparam int EXTRA_W  = 4;
    localparam int ROW_W    = DATA_W + EXTRA_W;

    typedef enum logic [1:0] {
        RDW_READ_FIRST  = 2'd0,
        RDW_WRITE_FIRST = 2'd1,
        RDW_NO_CHANGE   = 2'd2
    } rdw_e;

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [ROW_AW-1:0] row_idx_t;

    function automatic int data_bits(input int w);
        return (w < 9) ? w : (w / 9) * 8;
    endfunction

    function automatic int extra_bits(input int w);
        return (w < 9) ? 0 : w / 9;
    endfunction

    function automatic int slot_log2(input int w);
        return $clog2(DATA_W / data_bits(w));
    endfunction

    function automatic int addr_bits(input int w);
        return ROW_AW + slot_log2(w);
    endfunction

endpackage

// File: rtl/mwdp_array.sv
module mwdp_array
    import mwdp_pkg::*;
(
    input  logic     clk,
    input  logic     a_wr,
    input  row_idx_t a_row,
    input  row_t     a_mask,
    input  row_t     a_word,
    output row_t     a_rd_row,
    input  logic     b_wr,
    input  row_idx_t b_row,
    input  row_t     b_mask,
    input  row_t     b_word,
    output row_t     b_rd_row
);

    row_t mem [ROWS];

    always_ff @(posedge clk) begin
        for (int bit_i = 0; bit_i < ROW_W; bit_i++) begin
            if (a_wr && a_mask[bit_i]) begin
                mem[a_row][bit_i] <= a_word[bit_i];
            end
            if (b_wr && b_mask[bit_i]) begin
                mem[b_row][bit_i] <= b_word[bit_i];
            end
        end
    end

    assign a_rd_row = mem[a_row];
    assign b_rd_row = mem[b_row];

endmodule

// File: rtl/mwdp_port.sv
module mwdp_port
    import mwdp_pkg::*;
#(
    parameter int   W       = 36,
    parameter rdw_e MODE    = RDW_READ_FIRST,
    parameter bit   OUT_REG = 1'b0,
    localparam int  AW      = addr_bits(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          wr,
    output row_idx_t      row,
    output row_t          wmask,
    output row_t          wword,
    input  row_t          rd_row
);

    localparam int DW    = data_bits(W);
    localparam int PW    = extra_bits(W);
    localparam int SL    = slot_log2(W);
    localparam int SLOTS = 1 << SL;
    localparam int SLW   = (SL > 0) ? SL : 1;

    logic [SLW-1:0]   slot;
    logic [SLOTS-1:0] hit;
    logic [W-1:0]     cand [SLOTS];
    logic [W-1:0]     rd_val;
    logic [W-1:0]     lat_q;

    assign wr  = en & we;
    assign row = row_idx_t'(addr >> SL);

    if (SL > 0) begin : g_slot
        assign slot = addr[SL-1:0];
    end else begin : g_noslot
        assign slot = 1'b0;
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_lane
        assign hit[k] = (SL == 0) || (slot == SLW'(k));
        assign wmask[k*DW +: DW] = {DW{hit[k]}};
        assign wword[k*DW +: DW] = din[DW-1:0];
        if (PW > 0) begin : g_ext
            assign wmask[DATA_W + k*PW +: PW] = {PW{hit[k]}};
            assign wword[DATA_W + k*PW +: PW] = din[W-1:DW];
            assign cand[k] = {rd_row[DATA_W + k*PW +: PW], rd_row[k*DW +: DW]};
        end else begin : g_noext
            assign cand[k] = rd_row[k*DW +: DW];
        end
    end

    if (PW == 0) begin : g_noext_bits
        logic unused_ext;
        assign wmask[ROW_W-1:DATA_W] = '0;
        assign wword[ROW_W-1:DATA_W] = '0;
        assign unused_ext = ^rd_row[ROW_W-1:DATA_W];
    end

    if (SL > 0) begin : g_rsel
        assign rd_val = cand[slot];
    end else begin : g_rone
        assign rd_val = cand[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (en) begin
            if (!we) begin
                lat_q <= rd_val;
            end else begin
                unique case (MODE)
                    RDW_READ_FIRST:  lat_q <= rd_val;
                    RDW_WRITE_FIRST: lat_q <= din;
                    default:         lat_q <= lat_q;
                endcase
            end
        end
    end

    if (OUT_REG) begin : g_oreg
        logic [W-1:0] pipe_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= lat_q;
            end
        end
        assign dout = pipe_q;
    end else begin : g_ocomb
        assign dout = lat_q;
    end

endmodule

// File: rtl/mwdp_ram.sv
module mwdp_ram
    import mwdp_pkg::*;
#(
    parameter int   A_WIDTH   = 36,
    parameter int   B_WIDTH   = 9,
    parameter rdw_e A_MODE    = RDW_READ_FIRST,
    parameter rdw_e B_MODE    = RDW_WRITE_FIRST,
    parameter bit   A_OUT_REG = 1'b0,
    parameter bit   B_OUT_REG = 1'b1,
    localparam int  A_AW      = addr_bits(A_WIDTH),
    localparam int  B_AW      = addr_bits(B_WIDTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               a_en,
    input  logic               a_we,
    input  logic [A_AW-1:0]    a_addr,
    input  logic [A_WIDTH-1:0] a_din,
    output logic [A_WIDTH-1:0] a_dout,
    input  logic               b_en,
    input  logic               b_we,
    input  logic [B_AW-1:0]    b_addr,
    input  logic [B_WIDTH-1:0] b_din,
    output logic [B_WIDTH-1:0] b_dout
);

    logic     a_wr, b_wr;
    row_idx_t a_row, b_row;
    row_t     a_mask, b_mask, a_word, b_word, a_rd_row, b_rd_row;

    mwdp_port #(.W(A_WIDTH), .MODE(A_MODE), .OUT_REG(A_OUT_REG)) u_port_a (
        .clk(clk), .rst(rst), .en(a_en), .we(a_we), .addr(a_addr),
        .din(a_din), .dout(a_dout), .wr(a_wr), .row(a_row),
        .wmask(a_mask), .wword(a_word), .rd_row(a_rd_row)
    );

    mwdp_port #(.W(B_WIDTH), .MODE(B_MODE), .OUT_REG(B_OUT_REG)) u_port_b (
        .clk(clk), .rst(rst), .en(b_en), .we(b_we), .addr(b_addr),
        .din(b_din), .dout(b_dout), .wr(b_wr), .row(b_row),
        .wmask(b_mask), .wword(b_word), .rd_row(b_rd_row)
    );

    mwdp_array u_array (
        .clk(clk),
        .a_wr(a_wr), .a_row(a_row), .a_mask(a_mask), .a_word(a_word), .a_rd_row(a_rd_row),
        .b_wr(b_wr), .b_row(b_row), .b_mask(b_mask), .b_word(b_word), .b_rd_row(b_rd_row)
    );

endmodule

// File: rtl/mwdp_ram_chk.sv
module mwdp_ram_chk
    import mwdp_pkg::*;
#(
    parameter int   A_WIDTH   = 36,
    parameter int   B_WIDTH   = 9,
    parameter rdw_e A_MODE    = RDW_READ_FIRST,
    parameter rdw_e B_MODE    = RDW_WRITE_FIRST,
    parameter bit   A_OUT_REG = 1'b0,
    parameter bit   B_OUT_REG = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic               a_en,
    input logic               a_we,
    input logic [A_WIDTH-1:0] a_din,
    input logic [A_WIDTH-1:0] a_dout,
    input logic               b_en,
    input logic               b_we,
    input logic [B_WIDTH-1:0] b_din,
    input logic [B_WIDTH-1:0] b_dout
);

    if (!A_OUT_REG) begin : g_a_direct
        a_r8_idle_a: assert property (@(posedge clk) disable iff (rst)
            !a_en |=> $stable(a_dout));
        a_r7_nochange_a: assert property (@(posedge clk) disable iff (rst)
            (A_MODE == RDW_NO_CHANGE) && a_en && a_we |=> $stable(a_dout));
        a_r6_wfirst_a: assert property (@(posedge clk) disable iff (rst)
            (A_MODE == RDW_WRITE_FIRST) && a_en && a_we |=> a_dout == $past(a_din));
    end else begin : g_a_piped
        a_r8_idle_a: assert property (@(posedge clk) disable iff (rst)
            $past(!a_en) |=> $stable(a_dout));
        a_r7_nochange_a: assert property (@(posedge clk) disable iff (rst)
            (A_MODE == RDW_NO_CHANGE) && $past(a_en && a_we) |=> $stable(a_dout));
        a_r6_wfirst_a: assert property (@(posedge clk) disable iff (rst)
            (A_MODE == RDW_WRITE_FIRST) && $past(a_en && a_we) |=> a_dout == $past(a_din, 2));
    end

    if (!B_OUT_REG) begin : g_b_direct
        a_r8_idle_b: assert property (@(posedge clk) disable iff (rst)
            !b_en |=> $stable(b_dout));
        a_r7_nochange_b: assert property (@(posedge clk) disable iff (rst)
            (B_MODE == RDW_NO_CHANGE) && b_en && b_we |=> $stable(b_dout));
        a_r6_wfirst_b: assert property (@(posedge clk) disable iff (rst)
            (B_MODE == RDW_WRITE_FIRST) && b_en && b_we |=> b_dout == $past(b_din));
    end else begin : g_b_piped
        a_r8_idle_b: assert property (@(posedge clk) disable iff (rst)
            $past(!b_en) |=> $stable(b_dout));
        a_r7_nochange_b: assert property (@(posedge clk) disable iff (rst)
            (B_MODE == RDW_NO_CHANGE) && $past(b_en && b_we) |=> $stable(b_dout));
        a_r6_wfirst_b: assert property (@(posedge clk) disable iff (rst)
            (B_MODE == RDW_WRITE_FIRST) && $past(b_en && b_we) |=> b_dout == $past(b_din, 2));
    end

endmodule

bind mwdp_ram mwdp_ram_chk #(
    .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .A_MODE(A_MODE), .B_MODE(B_MODE),
    .A_OUT_REG(A_OUT_REG), .B_OUT_REG(B_OUT_REG)
) u_chk (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_din(a_din), .a_dout(a_dout),
    .b_en(b_en), .b_we(b_we), .b_din(b_din), .b_dout(b_dout)
);

// File: tb/mwdp_ram_test.sv
`timescale 1ns/1ps
module mwdp_ram_test;
    import mwdp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // uut: A is 512x36 read-first direct, B is 2048x9 write-first registered
    logic        a_en = 0, a_we = 0;
    logic [8:0]  a_addr = '0;
    logic [35:0] a_din = '0, a_dout;
    logic        b_en = 0, b_we = 0;
    logic [10:0] b_addr = '0;
    logic [8:0]  b_din = '0, b_dout;

    // uut2: C is 4096x4 no-change direct, D is 1024x18 read-first direct
    logic        c_en = 0, c_we = 0;
    logic [11:0] c_addr = '0;
    logic [3:0]  c_din = '0, c_dout;
    logic        d_en = 0, d_we = 0;
    logic [9:0]  d_addr = '0;
    logic [17:0] d_din = '0, d_dout;

    mwdp_ram #(.A_WIDTH(36), .B_WIDTH(9), .A_MODE(RDW_READ_FIRST), .B_MODE(RDW_WRITE_FIRST),
               .A_OUT_REG(1'b0), .B_OUT_REG(1'b1)) uut (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout));

    mwdp_ram #(.A_WIDTH(4), .B_WIDTH(18), .A_MODE(RDW_NO_CHANGE), .B_MODE(RDW_READ_FIRST),
               .A_OUT_REG(1'b0), .B_OUT_REG(1'b0)) uut2 (
        .clk(clk), .rst(rst),
        .a_en(c_en), .a_we(c_we), .a_addr(c_addr), .a_din(c_din), .a_dout(c_dout),
        .b_en(d_en), .b_we(d_we), .b_addr(d_addr), .b_din(d_din), .b_dout(d_dout));

    typedef struct packed {
        logic [8:0]  row;
        logic [35:0] word;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{row: 9'd0,   word: 36'hA_1234_5678},
        '{row: 9'd511, word: 36'h5_DEAD_BEEF},
        '{row: 9'd100, word: 36'hF_0000_FFFF},
        '{row: 9'd257, word: 36'h0_8001_7FFE}
    };

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R2: x9 slot s of a 36-bit row is {row[32+s], row[8s +: 8]}
    function automatic logic [8:0] slot9(input logic [35:0] w, input int s);
        return {w[32+s], w[8*s +: 8]};
    endfunction

    function automatic logic [35:0] merge9(input logic [35:0] w, input int s, input logic [8:0] v);
        logic [35:0] r = w;
        r[8*s +: 8] = v[7:0];
        r[32+s]     = v[8];
        return r;
    endfunction

    task automatic cyc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic a_write(input logic [8:0] row, input logic [35:0] w);
        a_en = 1; a_we = 1; a_addr = row; a_din = w;
        cyc();
        a_en = 0; a_we = 0;
    endtask

    task automatic a_read(input logic [8:0] row);
        a_en = 1; a_we = 0; a_addr = row;
        cyc();
        a_en = 0;
    endtask

    task automatic b_read(input logic [10:0] addr);
        b_en = 1; b_we = 0; b_addr = addr;
        cyc();
        b_en = 0;
        cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0]  prev_b;
        logic [35:0] expw;
        @(negedge clk);
        repeat (3) cyc();
        rst = 0;
        cyc();
        check("R10 reset clears port A output", a_dout, 36'h0);
        check("R10 reset clears port B output", {27'h0, b_dout}, 36'h0);
        check("R10 reset clears port C output", {32'h0, c_dout}, 36'h0);

        // vector table: wide write, wide read-back, narrow read of each slot
        for (int i = 0; i < 4; i++) begin
            a_write(VEC[i].row, VEC[i].word);
            a_read(VEC[i].row);
            check("R3 wide read-back after capturing edge", a_dout, VEC[i].word);
            for (int s = 0; s < 4; s++) begin
                b_read({VEC[i].row, 2'(s)});
                check("R2 x9 slot of x36 row", {27'h0, b_dout}, {27'h0, slot9(VEC[i].word, s)});
            end
        end

        // R5: read-first shows old contents
        a_write(9'd100, 36'h1_2222_3333);
        check("R5 read-first shows old word", a_dout, 36'hF_0000_FFFF);
        a_read(9'd100);
        check("R5 new word stored", a_dout, 36'h1_2222_3333);

        // R6 + R4: write-first through registered x9 port
        prev_b = b_dout;
        b_en = 1; b_we = 1; b_addr = {9'd100, 2'd1}; b_din = 9'h1AB;
        cyc();
        b_en = 0; b_we = 0;
        check("R4 registered output still previous", {27'h0, b_dout}, {27'h0, prev_b});
        cyc();
        check("R6 write-first shows written data", {27'h0, b_dout}, {27'h0, 9'h1AB});
        a_read(9'd100);
        check("R2 narrow write lands in slot 1 with extra bit", a_dout,
              merge9(36'h1_2222_3333, 1, 9'h1AB));

        // R8 + R9: enable low ignores we/addr/din, outputs hold
        b_read({9'd511, 2'd2});
        prev_b = b_dout;
        a_read(9'd0);
        a_we = 1; a_addr = 9'd0; a_din = 36'h0;
        b_we = 1; b_addr = {9'd511, 2'd2}; b_din = 9'h000;
        repeat (4) cyc();
        check("R8 port A output holds with enable low", a_dout, VEC[0].word);
        check("R9 port B output holds over idle cycles", {27'h0, b_dout}, {27'h0, prev_b});
        a_we = 0; b_we = 0;
        a_read(9'd0);
        check("R8 no write with enable low (A)", a_dout, VEC[0].word);
        a_read(9'd511);
        check("R8 no write with enable low (B)", a_dout, VEC[1].word);

        // R11: both ports write in the same cycle, different rows
        a_write(9'd301, 36'h0);
        a_en = 1; a_we = 1; a_addr = 9'd300; a_din = 36'h6_CAFE_F00D;
        b_en = 1; b_we = 1; b_addr = {9'd301, 2'd2}; b_din = 9'h0C5;
        cyc();
        a_en = 0; a_we = 0; b_en = 0; b_we = 0;
        cyc();
        a_read(9'd300);
        check("R11 port A write kept", a_dout, 36'h6_CAFE_F00D);
        a_read(9'd301);
        expw = merge9(36'h0, 2, 9'h0C5);
        check("R11 port B write kept", a_dout, expw);

        // uut2: x18 writes, x4 reads (R1 12-bit and 10-bit addresses)
        d_en = 1; d_we = 1; d_addr = {9'd7, 1'b0}; d_din = 18'h2_1234;
        cyc();
        d_addr = {9'd7, 1'b1}; d_din = 18'h1_ABCD;
        cyc();
        d_en = 0; d_we = 0;
        for (int s = 0; s < 8; s++) begin
            c_en = 1; c_we = 0; c_addr = {9'd7, 3'(s)};
            cyc();
            c_en = 0;
            check("R2 x4 slot of row written by x18", {32'h0, c_dout},
                  {32'h0, 32'hABCD_1234 >> (4*s)} & 36'hF);
        end

        // R7: no-change mode holds output during write
        c_en = 1; c_we = 0; c_addr = {9'd7, 3'd0};
        cyc();
        c_we = 1; c_addr = {9'd7, 3'd1}; c_din = 4'h9;
        cyc();
        c_en = 0; c_we = 0;
        check("R7 no-change output held on write", {32'h0, c_dout}, 36'h4);
        d_en = 1; d_we = 0; d_addr = {9'd7, 1'b0};
        cyc();
        d_en = 0;
        check("R2 x4 write visible in x18 slot with extra bits", {18'h0, d_dout}, {18'h0, 18'h2_1294});

        // R5 on x18 port: read-first returns old slot
        d_en = 1; d_we = 1; d_addr = {9'd7, 1'b1}; d_din = 18'h3_0000;
        cyc();
        d_en = 0; d_we = 0;
        check("R5 read-first x18 shows old slot", {18'h0, d_dout}, {18'h0, 18'h1_ABCD});

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule